// File: doc/BRIEF.md
# Synchronous On-Die Termination Timing Engine

This block sits on the memory-device side and converts the registered external termination-control pin into an internal termination-enable signal. It is active only while the device can keep its clocks aligned. The delay between sampling the pin and acting on it is worked out while running from three inputs: the programmed CAS write latency, the additive-latency code and the CAS latency. Because of that, a change of mode-register values takes effect without any rebuild.

The engine also checks how long the termination pin stays high. Once the pin is seen high, it must remain high for a minimum number of clock edges. A write that is registered while the pin is high starts a fresh minimum window, and the length of that window depends on whether the access is burst-chop or full burst. If the pin is sampled low too early, the engine raises a one-cycle flag.

Top module: `odt_sync_engine`

## Requirements
- R1: `sync_mode` is high only when `dll_locked` is high and at least one of `rtt_nom_en` and `rtt_wr_en` is high.
- R2: Under the R1 conditions, `sync_mode` is high whenever `cke` is high. With `cke` low it is high for active power-down (`pd_is_active`=1), and for precharge power-down (`pd_is_active`=0) only when `dll_pd_keep` is 1.
- R3: `term_en` is low in every cycle in which `sync_mode` is low.
- R4: The rising edge of `clk` that samples `odt_in` high at edge k makes `term_en` high after edge k+L, where L = CWL + AL − 2. This holds while sync mode stays on.
- R5: The edge that samples `odt_in` low at edge k makes `term_en` low after edge k+L, using the same L.
- R6: AL is decoded from `al_code` as follows: 2'b00 gives 0, 2'b01 gives `cl`−1, and 2'b10 gives `cl`−2.
- R7: `cfg_err` is high when `al_code` is 2'b11 (AL is then taken as 0), when `cwl` is below 5, or when `cwl` is above 12. Otherwise it is low.
- R8: If `odt_in` is sampled high at edge k after being sampled low at edge k−1, then sampling it low at edge k+m with m < 4 is a hold violation.
- R9: A write registered (`wr_cmd`=1) at an edge that samples `odt_in` high restarts the window from that edge. The window is 6 edges when `wr_bl8`=1 and 4 edges when `wr_bl8`=0, even if a longer earlier window is still running.
- R10: `hold_viol` is high for exactly the one cycle that follows the violating edge, and only if `sync_mode` was high at that edge.
- R11: While `rst_n` is low, the delay pipeline and the hold window are cleared, and `term_en` and `hold_viol` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| odt_in | input | 1 | Termination-control pin |
| wr_cmd | input | 1 | A write command is registered at this edge |
| wr_bl8 | input | 1 | 1 = full burst of 8, 0 = burst-chop 4 |
| cwl | input | 4 | CAS write latency, valid range 5..12 |
| cl | input | 4 | CAS latency, used for the AL decode |
| al_code | input | 2 | Additive-latency code |
| dll_locked | input | 1 | DLL is on and locked |
| cke | input | 1 | Clock-enable level |
| pd_is_active | input | 1 | Power-down type while cke is low: 1 = active, 0 = precharge |
| dll_pd_keep | input | 1 | DLL stays on in precharge power-down |
| rtt_nom_en | input | 1 | Nominal termination is enabled |
| rtt_wr_en | input | 1 | Write termination is enabled |
| term_en | output | 1 | Delayed internal termination enable |
| sync_mode | output | 1 | Synchronous mode is active |
| hold_viol | output | 1 | One-cycle pulse when the minimum-high rule is broken |
| cfg_err | output | 1 | Latency configuration is reserved or out of range |

## Verification
All 64 combinations of the six mode-condition inputs are swept, which separates the DLL, termination and power-down terms of R1 and R2. Directed single pulses are sent with each AL code and several CWL and CL values, and the measured rise and fall delay is compared. This tells a wrong AL decode apart from an off-by-one in the tap. Random pin traffic uses short pulses and writes of both burst types at random offsets. It is checked every cycle against a bench model of the delay line and the hold windows, so that a write which shortens or lengthens the window is distinguished from a plain rise. Directed hold sequences sit exactly at the 4- and 6-edge boundaries.

// File: rtl/odt_sync_engine.sv
module odt_sync_engine #(
  parameter int DEPTH      = 32,
  parameter int SHORT_HOLD = 4,
  parameter int LONG_HOLD  = 6,
  parameter int CWL_MIN    = 5,
  parameter int CWL_MAX    = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       odt_in,
  input  logic       wr_cmd,
  input  logic       wr_bl8,
  input  logic [3:0] cwl,
  input  logic [3:0] cl,
  input  logic [1:0] al_code,
  input  logic       dll_locked,
  input  logic       cke,
  input  logic       pd_is_active,
  input  logic       dll_pd_keep,
  input  logic       rtt_nom_en,
  input  logic       rtt_wr_en,
  output logic       term_en,
  output logic       sync_mode,
  output logic       hold_viol,
  output logic       cfg_err
);
  localparam int IW = $clog2(DEPTH);
  localparam int HW = $clog2(LONG_HOLD + 1);

  logic [DEPTH-1:0] pipe;
  logic [4:0]       al_val;
  logic [5:0]       lat_sum;
  logic [5:0]       lat_m2;
  logic [IW-1:0]    tap_idx;
  logic [HW-1:0]    rem;
  logic             odt_q;

  always_comb begin
    case (al_code)
      2'b01:   al_val = (cl != 4'd0) ? {1'b0, cl} - 5'd1 : 5'd0;
      2'b10:   al_val = (cl > 4'd1)  ? {1'b0, cl} - 5'd2 : 5'd0;
      default: al_val = 5'd0;
    endcase
  end

  assign lat_sum = {2'b00, cwl} + {1'b0, al_val};
  assign lat_m2  = lat_sum - 6'd2;

  always_comb begin
    if (lat_sum < 6'd2)                 tap_idx = '0;
    else if (lat_m2 > 6'(DEPTH - 1))    tap_idx = IW'(DEPTH - 1);
    else                                tap_idx = lat_m2[IW-1:0];
  end

  assign cfg_err   = (al_code == 2'b11) | (cwl < 4'(CWL_MIN)) | (cwl > 4'(CWL_MAX));
  assign sync_mode = dll_locked & (rtt_nom_en | rtt_wr_en) & (cke | pd_is_active | dll_pd_keep);
  assign odt_q     = pipe[0];
  assign term_en   = sync_mode & pipe[tap_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[DEPTH-2:0], odt_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem       <= '0;
      hold_viol <= 1'b0;
    end else begin
      hold_viol <= sync_mode & odt_q & ~odt_in & (rem != '0);
      if (!odt_in)      rem <= '0;
      else if (wr_cmd)  rem <= wr_bl8 ? HW'(LONG_HOLD - 1) : HW'(SHORT_HOLD - 1);
      else if (!odt_q)  rem <= HW'(SHORT_HOLD - 1);
      else if (rem != '0) rem <= rem - 1'b1;
    end
  end

  AST_VIOL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    hold_viol |=> !hold_viol); // R10
  AST_VIOL_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    hold_viol |-> !odt_q); // R8
  AST_RISE_ARMS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(odt_q) |-> rem != '0); // R8
  AST_WRITE_ARMS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && odt_in) |=> rem >= HW'(SHORT_HOLD - 1)); // R9
  AST_TERM_FOLLOWS_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(term_en) && $past(sync_mode) && $stable(tap_idx) && tap_idx != '0)
      |-> $past(pipe[tap_idx - 1'b1])); // R4
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!term_en && !hold_viol)); // R11
endmodule

// File: tb/odt_sync_engine_bench.sv
`timescale 1ns/1ps
module odt_sync_engine_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic odt_in = 0, wr_cmd = 0, wr_bl8 = 0;
  logic [3:0] cwl = 4'd5, cl = 4'd6;
  logic [1:0] al_code = 2'b00;
  logic dll_locked = 1, cke = 1, pd_is_active = 0, dll_pd_keep = 0, rtt_nom_en = 1, rtt_wr_en = 0;
  logic term_en, sync_mode, hold_viol, cfg_err;

  int total = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  odt_sync_engine u_odt_sync_engine (
    .clk(clk), .rst_n(rst_n), .odt_in(odt_in), .wr_cmd(wr_cmd), .wr_bl8(wr_bl8),
    .cwl(cwl), .cl(cl), .al_code(al_code), .dll_locked(dll_locked), .cke(cke),
    .pd_is_active(pd_is_active), .dll_pd_keep(dll_pd_keep), .rtt_nom_en(rtt_nom_en),
    .rtt_wr_en(rtt_wr_en), .term_en(term_en), .sync_mode(sync_mode),
    .hold_viol(hold_viol), .cfg_err(cfg_err));

  function automatic bit f_sync(bit dl, bit rn, bit rw, bit ck, bit pa, bit dk);
    return dl && (rn || rw) && (ck || pa || (!pa && dk));
  endfunction

  function automatic int f_lat(logic [3:0] w, logic [3:0] c, logic [1:0] a);
    int al;
    al = (a == 2'b01) ? int'(c) - 1 : (a == 2'b10) ? int'(c) - 2 : 0;
    return int'(w) + al - 2;
  endfunction

  task automatic chk(bit got, bit exp, string tag);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  logic [63:0] hist;
  int cyc, evt, need;
  bit prev_odt, exp_viol;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '0; prev_odt = 0; exp_viol = 0; cyc = 0; evt = 0; need = 0;
    end else begin
      exp_viol = f_sync(dll_locked, rtt_nom_en, rtt_wr_en, cke, pd_is_active, dll_pd_keep)
                 && prev_odt && !odt_in && (cyc - evt < need);
      if (odt_in && wr_cmd) begin evt = cyc; need = wr_bl8 ? 6 : 4; end
      else if (odt_in && !prev_odt) begin evt = cyc; need = 4; end
      prev_odt = odt_in;
      hist = {hist[62:0], odt_in};
      cyc++;
    end
  end

  task automatic model_check();
    bit es;
    bit et;
    es = f_sync(dll_locked, rtt_nom_en, rtt_wr_en, cke, pd_is_active, dll_pd_keep);
    et = es && hist[f_lat(cwl, cl, al_code)];
    chk(sync_mode, es, "R1 R2 sync_mode");
    if (!es)      chk(term_en, 1'b0, "R3 term_en off");
    else if (et)  chk(term_en, et, "R4 term_en");
    else          chk(term_en, et, "R5 term_en");
    chk(hold_viol, exp_viol, "R8 R9 R10 hold_viol");
  endtask

  task automatic cyc_drive(bit o, bit w, bit b);
    @(negedge clk);
    model_check();
    odt_in = o; wr_cmd = w; wr_bl8 = b;
  endtask

  task automatic measure(bit level, int expct, string tag);
    int n;
    n = 0;
    @(negedge clk); odt_in = level;
    do begin @(negedge clk); n++; end while (term_en !== level && n < 60);
    total++;
    if (n - 1 != expct) begin
      fails++;
      $display("FAIL %s: latency got %0d expected %0d", tag, n - 1, expct);
    end
  endtask

  task automatic hold_seq(bit w, bit b, int wr_at, int low_at, bit exp_any, string tag);
    int seen;
    seen = 0;
    for (int i = 0; i < 10; i++) cyc_drive(0, 0, 0);
    for (int i = 0; i < low_at + 4; i++) begin
      cyc_drive(i < low_at, w && (i == wr_at), b);
      if (hold_viol) seen++;
    end
    total++;
    if ((seen != 0) != exp_any) begin
      fails++;
      $display("FAIL %s: violation seen %0d expected %0b", tag, seen, exp_any);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    fails++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    odt_in = 1;
    repeat (4) @(negedge clk);
    chk(term_en, 1'b0, "R11 term_en in reset");
    chk(hold_viol, 1'b0, "R11 hold_viol in reset");
    odt_in = 0;
    rst_n = 1;

    // R7 configuration error
    #1 al_code = 2'b11; #1 chk(cfg_err, 1'b1, "R7 reserved al");
    al_code = 2'b00; cwl = 4'd4; #1 chk(cfg_err, 1'b1, "R7 cwl low");
    cwl = 4'd13; #1 chk(cfg_err, 1'b1, "R7 cwl high");
    cwl = 4'd12; #1 chk(cfg_err, 1'b0, "R7 valid");
    cwl = 4'd5;

    // R1 R2 sweep
    for (int v = 0; v < 64; v++) begin
      {dll_locked, rtt_nom_en, rtt_wr_en, cke, pd_is_active, dll_pd_keep} = 6'(v);
      #1 chk(sync_mode, f_sync(v[5], v[4], v[3], v[2], v[1], v[0]), "R1 R2 sweep");
    end
    {dll_locked, rtt_nom_en, rtt_wr_en, cke, pd_is_active, dll_pd_keep} = 6'b110100;

    // R4 R5 R6 latency with each AL code
    for (int k = 0; k < 6; k++) begin
      cwl = 4'(5 + k); cl = 4'(5 + k); al_code = 2'(k % 3);
      repeat (40) @(negedge clk);
      measure(1, f_lat(cwl, cl, al_code), "R4 R6 rise");
      repeat (30) @(negedge clk);
      measure(0, f_lat(cwl, cl, al_code), "R5 R6 fall");
    end
    odt_in = 0;

    // R8 R9 hold boundaries
    cwl = 4'd6; cl = 4'd6; al_code = 2'b00;
    hold_seq(0, 0, 0, 3, 1, "R8 short high");
    hold_seq(0, 0, 0, 4, 0, "R8 exact minimum");
    hold_seq(1, 1, 1, 6, 1, "R9 bl8 early drop");
    hold_seq(1, 1, 1, 7, 0, "R9 bl8 exact");
    hold_seq(1, 0, 2, 5, 1, "R9 bc4 restart");
    hold_seq(1, 0, 2, 6, 0, "R9 bc4 exact");
    hold_seq(1, 0, 0, 3, 1, "R9 write at rise");

    // random traffic
    for (int blk = 0; blk < 40; blk++) begin
      cwl = 4'(5 + $urandom_range(0, 7));
      cl  = 4'(5 + $urandom_range(0, 6));
      al_code = 2'($urandom_range(0, 2));
      dll_locked = ($urandom_range(0, 7) != 0);
      rtt_nom_en = $urandom_range(0, 1);
      rtt_wr_en = ($urandom_range(0, 3) != 0);
      cke = ($urandom_range(0, 3) != 0);
      pd_is_active = $urandom_range(0, 1);
      dll_pd_keep = $urandom_range(0, 1);
      for (int i = 0; i < 300; i++) begin
        bit o;
        o = ($urandom_range(0, 4) == 0) ? !odt_in : odt_in;
        cyc_drive(o, o && ($urandom_range(0, 5) == 0), $urandom_range(0, 1));
      end
    end

    // R11 reset mid-stream
    odt_in = 1;
    repeat (30) @(negedge clk);
    rst_n = 0;
    #1 chk(term_en, 1'b0, "R11 term_en cleared");
    chk(hold_viol, 1'b0, "R11 hold_viol cleared");
    @(negedge clk);
    odt_in = 0;
    rst_n = 1;
    repeat (3) cyc_drive(0, 0, 0);
    @(negedge clk);
    chk(term_en, 1'b0, "R11 pipeline empty after reset");

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule